// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management-interface slave that opens a 32-bit, byte-addressed register space to a host that only speaks 16-bit Clause-22 MDIO frames. The five-bit PHY address of each frame is not used as a PHY address. Its top two bits choose what the frame does. Its low three bits, together with the five-bit register field and a stored page, form the internal address. One mode stores the page, which supplies the high address bits. Another mode moves one 16-bit half of a 32-bit register. The remaining codes belong to real PHYs sharing the bus, and the bridge leaves those frames alone.

Writes are split into two frames. The upper half is sent first and is only held inside the bridge. The lower-half write then issues one 32-bit write carrying both halves. This matters for registers whose action bit sits in the low half.

Reads are also split into two frames. A lower-half read fetches the whole register once and returns bits 15:0. The following upper-half read returns the held bits 31:16 without touching the internal bus, so both halves come from the same fetch.

The internal side is a valid/ready request port with a write flag, a 4-byte-aligned byte address, 32-bit write data, and 32-bit read data. Read data is taken in the cycle of the handshake.

Top module: `mdio_regbridge`

## Requirements
- R1: Bits [4:3] of the frame's PHY field select the mode. Code 3 is page, code 2 is register access, and codes 0 and 1 are not for the bridge. Frames with code 0 or 1 cause no bus request, leave the page unchanged, and never enable the MDIO driver.
- R2: A page-mode write stores data bits [PAGE_W-1:0] as the page, which forms address bits [18:9]. The page persists across frames. Reset clears the page and both held halves to zero.
- R3: In register mode the bus address is {page, PHY bits [2:0], register bits [4:1], 2'b00}. Register bit 0, which is byte-address bit 1, selects the half: 0 is bits 15:0 and 1 is bits 31:16.
- R4: An upper-half register write is held inside the bridge and produces no bus request.
- R5: A lower-half register write produces exactly one bus write. Its data is {held upper half, frame data}.
- R6: A lower-half register read produces exactly one bus read at the computed address. The frame returns read-data bits 15:0, and bits 31:16 are kept.
- R7: An upper-half register read returns the bits 31:16 kept from the most recent lower-half read and makes no bus request.
- R8: Page-mode reads are not answered: the MDIO driver stays disabled for the whole frame.
- R9: bus_valid, together with the address, write flag and write data, stays stable until bus_ready. The transfer completes in the cycle both are high, and read data is sampled in that cycle.
- R10: In an answered read frame, the first turnaround bit is left undriven and the second is driven 0. Then 16 data bits are driven MSB first, each changed after a falling MDC edge. The driver is released after the last bit.
- R11: A frame is accepted only after at least PRE_LEN consecutive ones, the start pattern 0 then 1, and an opcode of 10 (read) or 01 (write). Any other frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; MDC and MDIO are oversampled with it |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Sensed level of the MDIO line |
| mdio_o | output | 1 | Level driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO driver enable |
| bus_valid | output | 1 | Internal request valid |
| bus_ready | input | 1 | Internal request accepted |
| bus_write | output | 1 | 1 for a write request, 0 for a read |
| bus_addr | output | PAGE_W+9 | Byte address, 4-byte aligned |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled at the handshake |

## Verification
The assertions assume that MDC runs slowly against clk: each MDC phase lasts at least four clk cycles. They also assume that a bus read started by a lower-half read header completes before the third falling MDC edge of that frame. The host starts no new frame while a bus request is still pending. The stimulus keeps to these limits by holding each MDC phase for four clock cycles, answering bus requests within three cycles, and leaving idle time after every frame.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'd0,
    MODE_RSV  = 2'd1,
    MODE_REG  = 2'd2,
    MODE_PAGE = 2'd3
  } mdb_mode_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam int HALF_W = 16;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] rg;
  } mdb_hdr_t;
endpackage

// File: rtl/mdb_frame_rx.sv
module mdb_frame_rx import mdb_pkg::*; #(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              hdr_stb,
  output mdb_hdr_t          hdr,
  output logic              wr_stb,
  output logic [HALF_W-1:0] wr_data,
  input  logic              rd_claim,
  input  logic [HALF_W-1:0] rd_word
);
  localparam int PRE_CW = $clog2(PRE_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BODY} rx_state_e;

  rx_state_e          state_q;
  logic [2:0]         mdc_s;
  logic [1:0]         dat_s;
  logic [PRE_CW-1:0]  ones_q;
  logic [3:0]         hcnt_q;
  logic [11:0]        hsr_q;
  logic [4:0]         body_q;
  logic [4:0]         drv_q;
  logic               claim_q;
  logic [HALF_W-1:0]  wsr_q;
  mdb_hdr_t           hdr_q;
  logic               hdr_stb_q, wr_stb_q, oe_q, o_q;

  logic       rise, fall, bit_in;
  logic [1:0] op_c;
  logic [3:0] bit_idx;

  always_comb begin
    rise    = mdc_s[1] & ~mdc_s[2];
    fall    = ~mdc_s[1] & mdc_s[2];
    bit_in  = dat_s[1];
    op_c    = hsr_q[10:9];
    bit_idx = 4'(5'd17 - drv_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      mdc_s     <= '0;
      dat_s     <= '0;
      ones_q    <= '0;
      hcnt_q    <= '0;
      hsr_q     <= '0;
      body_q    <= '0;
      drv_q     <= '0;
      claim_q   <= 1'b0;
      wsr_q     <= '0;
      hdr_q     <= '0;
      hdr_stb_q <= 1'b0;
      wr_stb_q  <= 1'b0;
      oe_q      <= 1'b0;
      o_q       <= 1'b0;
    end else begin
      mdc_s     <= {mdc_s[1:0], mdc};
      dat_s     <= {dat_s[0], mdio_i};
      hdr_stb_q <= 1'b0;
      wr_stb_q  <= 1'b0;
      if (hdr_stb_q) claim_q <= rd_claim;
      if (rise) begin
        unique case (state_q)
          S_IDLE: begin
            if (bit_in) begin
              if (ones_q != PRE_CW'(PRE_LEN)) ones_q <= ones_q + 1'b1;
            end else begin
              if (ones_q == PRE_CW'(PRE_LEN)) begin
                state_q <= S_HDR;
                hcnt_q  <= '0;
              end
              ones_q <= '0;
            end
          end
          S_HDR: begin
            hsr_q  <= {hsr_q[10:0], bit_in};
            hcnt_q <= hcnt_q + 1'b1;
            if (hcnt_q == 4'd12) begin
              if (hsr_q[11] && (op_c == OP_RD || op_c == OP_WR)) begin
                state_q   <= S_BODY;
                hdr_q     <= '{rd: (op_c == OP_RD), phy: hsr_q[8:4], rg: {hsr_q[3:0], bit_in}};
                hdr_stb_q <= 1'b1;
                body_q    <= '0;
                drv_q     <= '0;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          S_BODY: begin
            body_q <= body_q + 1'b1;
            if (body_q >= 5'd2) wsr_q <= {wsr_q[HALF_W-2:0], bit_in};
            if (body_q == 5'd17) begin
              state_q  <= S_IDLE;
              wr_stb_q <= ~hdr_q.rd;
              claim_q  <= 1'b0;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
      if (fall) begin
        if (state_q == S_BODY && claim_q) begin
          if (drv_q == 5'd1) begin
            oe_q <= 1'b1;
            o_q  <= 1'b0;
          end else if (drv_q >= 5'd2 && drv_q <= 5'd17) begin
            oe_q <= 1'b1;
            o_q  <= rd_word[bit_idx];
          end else begin
            oe_q <= 1'b0;
          end
        end else begin
          oe_q <= 1'b0;
        end
        if (state_q == S_BODY && drv_q != 5'd31) drv_q <= drv_q + 1'b1;
      end
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign hdr_stb = hdr_stb_q;
  assign hdr     = hdr_q;
  assign wr_stb  = wr_stb_q;
  assign wr_data = wsr_q;

  // R10
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(fall));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_stb, wr_stb}));
endmodule

// File: rtl/mdb_xlate.sv
module mdb_xlate import mdb_pkg::*; #(
  parameter  int PAGE_W = 10,
  localparam int ADDR_W = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_stb,
  input  mdb_hdr_t          hdr,
  input  logic              wr_stb,
  input  logic [HALF_W-1:0] wr_data,
  output logic              rd_claim,
  output logic [HALF_W-1:0] rd_word,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] hi_wr_q, hi_rd_q, rd_word_q;
  logic              valid_q, write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;

  logic [1:0]        mode;
  logic              upper;
  logic [ADDR_W-1:0] req_addr;

  always_comb begin
    mode     = hdr.phy[4:3];
    upper    = hdr.rg[0];
    req_addr = {page_q, hdr.phy[2:0], hdr.rg[4:1], 2'b00};
    rd_claim = hdr.rd && (mode == MODE_REG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q    <= '0;
      hi_wr_q   <= '0;
      hi_rd_q   <= '0;
      rd_word_q <= '0;
      valid_q   <= 1'b0;
      write_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      if (valid_q && bus_ready) begin
        valid_q <= 1'b0;
        if (!write_q) begin
          rd_word_q <= bus_rdata[HALF_W-1:0];
          hi_rd_q   <= bus_rdata[31:HALF_W];
        end
      end
      if (hdr_stb && rd_claim) begin
        if (upper) begin
          rd_word_q <= hi_rd_q;
        end else begin
          valid_q <= 1'b1;
          write_q <= 1'b0;
          addr_q  <= req_addr;
        end
      end
      if (wr_stb) begin
        if (mode == MODE_PAGE) begin
          page_q <= wr_data[PAGE_W-1:0];
        end else if (mode == MODE_REG) begin
          if (upper) begin
            hi_wr_q <= wr_data;
          end else begin
            valid_q <= 1'b1;
            write_q <= 1'b1;
            addr_q  <= req_addr;
            wdata_q <= {hi_wr_q, wr_data};
          end
        end
      end
    end
  end

  assign rd_word   = rd_word_q;
  assign bus_valid = valid_q;
  assign bus_write = write_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

  // R5
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && mode == MODE_REG && !upper |=> bus_valid && bus_write && bus_wdata[HALF_W-1:0] == $past(wr_data));

  // R2
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(page_q));

  // R7
  hi_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb && rd_claim && upper && !bus_valid |=> !bus_valid);
endmodule

// File: rtl/mdio_regbridge.sv
module mdio_regbridge import mdb_pkg::*; #(
  parameter  int PAGE_W  = 10,
  parameter  int PRE_LEN = 32,
  localparam int ADDR_W  = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  logic              hdr_stb, wr_stb, rd_claim;
  mdb_hdr_t          hdr;
  logic [HALF_W-1:0] wr_data, rd_word;

  mdb_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .hdr_stb  (hdr_stb),
    .hdr      (hdr),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_claim (rd_claim),
    .rd_word  (rd_word)
  );

  mdb_xlate #(.PAGE_W(PAGE_W)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_stb   (hdr_stb),
    .hdr       (hdr),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_claim  (rd_claim),
    .rd_word   (rd_word),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // R1
  oe_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !mdio_oe);
endmodule

// File: tb/mdio_regbridge_tb.sv
`timescale 1ns/1ps
module mdio_regbridge_tb;
  localparam int PAGE_W = 10;
  localparam int ADDR_W = PAGE_W + 9;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic m_oe = 1'b0, m_bit = 1'b1;
  logic mdio_o, mdio_oe, line;
  logic bus_valid, bus_ready = 1'b0, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;

  int checks = 0, fails = 0;
  int txn_cnt = 0, rd_seq = 0, wait_cnt = 0, dly_seq = 0;
  logic last_we;
  logic [ADDR_W-1:0] last_addr;
  logic [31:0] last_wd, last_rd;
  logic oe_seen = 1'b0, smp, smp_oe;

  always #2.5 clk = ~clk;

  assign line = m_oe ? m_bit : (mdio_oe ? mdio_o : 1'b1);

  mdio_regbridge #(.PAGE_W(PAGE_W), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always @(negedge clk) begin
    if (mdio_oe) oe_seen = 1'b1;
    if (bus_valid && bus_ready) begin
      bus_ready = 1'b0;
    end else if (bus_valid) begin
      if (wait_cnt == 0) begin
        bus_rdata = {13'd0, bus_addr} * 32'h0009_E377 + rd_seq * 32'h0101_0001;
        bus_ready = 1'b1;
        last_we   = bus_write;
        last_addr = bus_addr;
        last_wd   = bus_wdata;
        last_rd   = bus_rdata;
        txn_cnt++;
        if (!bus_write) rd_seq++;
      end else begin
        wait_cnt--;
      end
    end else begin
      bus_ready = 1'b0;
      wait_cnt  = dly_seq;
      dly_seq   = (dly_seq + 1) % 3;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic drv, input logic val);
    mdc = 1'b0; m_oe = drv; m_bit = val;
    repeat (HALF) @(negedge clk);
    smp = line; smp_oe = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd, input int pre,
                       output logic [15:0] rd, output logic ta_ok);
    logic [12:0] hb;
    rd = '0; ta_ok = 1'b1; oe_seen = 1'b0;
    hb = {op, phy, rg, 1'b0};
    for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b1);
    send_bit(1'b1, st[1]);
    send_bit(1'b1, st[0]);
    for (int i = 12; i >= 1; i--) send_bit(1'b1, hb[i]);
    if (op == 2'b10) begin
      for (int i = 0; i < 18; i++) begin
        send_bit(1'b0, 1'b1);
        if (i == 0) ta_ok = ta_ok & !smp_oe;
        else if (i == 1) ta_ok = ta_ok & smp_oe & (smp == 1'b0);
        else rd = {rd[14:0], smp};
      end
    end else begin
      send_bit(1'b1, 1'b1);
      send_bit(1'b1, 1'b0);
      for (int i = 15; i >= 0; i--) send_bit(1'b1, wd[i]);
    end
    mdc = 1'b0; m_oe = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [15:0] r; logic t;
    frame(2'b01, 2'b01, phy, rg, d, 32, r, t);
  endtask

  task automatic rdf(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] r, output logic t);
    frame(2'b01, 2'b10, phy, rg, 16'h0, 32, r, t);
  endtask

  initial begin
    logic [15:0] r, hi, lo, hi_exp;
    logic t;
    int n0;
    logic [ADDR_W-1:0] ea;
    logic [9:0] pgs [2];
    pgs[0] = 10'h2C7; pgs[1] = 10'h3FF;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid && !mdio_oe, "R2", "reset outputs idle", {30'd0, bus_valid, mdio_oe}, 0);

    // R2 R3: page 0 after reset, held upper half is zero
    n0 = txn_cnt;
    wr(5'b10_011, 5'b00110, 16'hBEEF);
    chk(txn_cnt == n0 + 1, "R5", "reset-state lower write count", txn_cnt - n0, 1);
    chk(last_addr == {10'd0, 3'd3, 4'd3, 2'b00}, "R2", "page zero after reset", last_addr, {10'd0, 3'd3, 4'd3, 2'b00});
    chk(last_wd == 32'h0000_BEEF, "R2", "held upper zero after reset", last_wd, 32'h0000_BEEF);

    // Main sweep: R3 R4 R5 R6 R7 R10
    for (int pi = 0; pi < 2; pi++) begin
      wr(5'b11_101, 5'h11, {6'h3F, pgs[pi]});
      for (int p = 0; p < 8; p++) begin
        for (int wi = 0; wi < 3; wi++) begin
          int w;
          w  = (wi == 0) ? 0 : (wi == 1) ? 5 : 15;
          hi = 16'(p * 4099 + w * 131 + pi * 977);
          lo = ~hi ^ 16'h3C5A;
          ea = {pgs[pi], 3'(p), 4'(w), 2'b00};
          n0 = txn_cnt;
          wr({2'b10, 3'(p)}, {4'(w), 1'b1}, hi);
          chk(txn_cnt == n0, "R4", "upper write no bus", txn_cnt - n0, 0);
          wr({2'b10, 3'(p)}, {4'(w), 1'b0}, lo);
          chk(txn_cnt == n0 + 1 && last_we, "R5", "lower write one bus write", txn_cnt - n0, 1);
          chk(last_addr == ea, "R3", "write address", last_addr, ea);
          chk(last_wd == {hi, lo}, "R5", "write data order", last_wd, {hi, lo});
          rdf({2'b10, 3'(p)}, {4'(w), 1'b0}, r, t);
          chk(txn_cnt == n0 + 2 && !last_we, "R6", "lower read one bus read", txn_cnt - n0, 2);
          chk(last_addr == ea, "R3", "read address", last_addr, ea);
          chk(r == last_rd[15:0], "R6", "lower read data", r, last_rd[15:0]);
          chk(t, "R10", "turnaround", t, 1);
          hi_exp = last_rd[31:16];
          rdf({2'b10, 3'(p)}, {4'(w), 1'b1}, r, t);
          chk(txn_cnt == n0 + 2, "R7", "upper read no bus", txn_cnt - n0, 2);
          chk(r == hi_exp && t, "R7", "upper read held data", r, hi_exp);
        end
      end
    end

    // R1: modes 0 and 1 ignored
    for (int m = 0; m < 2; m++) begin
      n0 = txn_cnt;
      wr({2'(m), 3'd2}, 5'h00, 16'h0155);
      wr({2'(m), 3'd2}, 5'h01, 16'h0155);
      rdf({2'(m), 3'd2}, 5'h00, r, t);
      chk(txn_cnt == n0 && !oe_seen, "R1", "foreign mode ignored", txn_cnt - n0, 0);
    end
    wr(5'b10_001, 5'b00010, 16'h1234);
    ea = {10'h3FF, 3'd1, 4'd1, 2'b00};
    chk(last_addr == ea, "R1", "page unchanged by foreign writes", last_addr, ea);

    // R8: page read not answered
    n0 = txn_cnt;
    frame(2'b01, 2'b10, 5'b11_000, 5'h00, 16'h0, 32, r, t);
    chk(!oe_seen && txn_cnt == n0, "R8", "page read silent", {31'd0, oe_seen}, 0);

    // R11: bad start, bad opcodes, short preamble
    n0 = txn_cnt;
    frame(2'b00, 2'b01, 5'b10_000, 5'h00, 16'h1111, 32, r, t);
    chk(txn_cnt == n0, "R11", "bad start ignored", txn_cnt - n0, 0);
    frame(2'b01, 2'b11, 5'b10_000, 5'h00, 16'h2222, 32, r, t);
    frame(2'b01, 2'b00, 5'b10_000, 5'h00, 16'h3333, 32, r, t);
    chk(txn_cnt == n0, "R11", "bad opcode ignored", txn_cnt - n0, 0);
    wr(5'b10_000, 5'b00001, 16'h0);
    n0 = txn_cnt;
    frame(2'b01, 2'b01, 5'b10_000, 5'h00, 16'h4444, 16, r, t);
    chk(txn_cnt == n0, "R11", "short preamble ignored", txn_cnt - n0, 0);

    // R2: reset clears page mid-run
    wr(5'b11_000, 5'h00, 16'h0155);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(5'b10_111, 5'b11110, 16'hA5A5);
    ea = {10'd0, 3'd7, 4'd15, 2'b00};
    chk(last_addr == ea && last_we, "R2", "page cleared by reset", last_addr, ea);
    chk(last_wd == 32'h0000_A5A5, "R9", "write data at handshake", last_wd, 32'h0000_A5A5);

    summary();
  end
endmodule